// File: doc/BRIEF.md
# Thermal Luminance Override Controller

This block picks the scan rate of an emissive panel from two digital luminance-select inputs. It turns that choice into a one-cycle scan enable pulse at the matching rate, derived from the reference clock. Three scan rates exist: fast (roughly 325 Hz), mid (roughly 240 Hz) and slow (roughly 180 Hz). Driving both select inputs high requests self-test, which scans at the fast rate.

A signed board-temperature reading in whole degrees C arrives with a one-cycle valid strobe. When a valid reading exceeds the upper threshold, the controller latches an over-temperature state. In that state it forces the slow rate, whatever the select inputs say, self-test included. The state clears only when a valid reading falls below the lower threshold, or on reset. The gap between the two thresholds gives hysteresis.

The thermal logic never stops the scan and never touches pixel data. It only slows the scan enable. Whenever the chosen rate changes, the divider restarts from zero, so no short or stretched interval is produced.

Top module: `thermal_lum_ctrl`

## Requirements
- R1: While reset is asserted, and directly after it, over_temp_o is 0, rate_code_o is 0 and scan_tick_o is 0. Asserting reset clears an active over-temperature state at once.
- R2: Outside over-temperature, rate_code_o follows {lum1_i,lum0_i} one clock after a change:
  - 00 gives code 0 (fast).
  - lum0_i=1 with lum1_i=0 gives code 1 (mid).
  - lum0_i=0 with lum1_i=1 gives code 2 (slow).
  - 11 gives code 3 (self-test).
- R3: With over_temp_o low, a valid reading strictly greater than ENTER_C (default 100) sets over_temp_o at the next clock. A reading equal to ENTER_C does not.
- R4: With over_temp_o high, a valid reading strictly less than EXIT_C (default 92) clears it at the next clock. Valid readings from EXIT_C to ENTER_C inclusive leave it set.
- R5: A reading presented with temp_valid_i low never changes over_temp_o. Readings are compared as two's-complement signed values, so a negative reading never enters over-temperature.
- R6: One clock after over_temp_o is high, rate_code_o is 2 for every select-input combination, including 11.
- R7: scan_tick_o is a one-cycle pulse. In steady state it repeats every DIV_FAST clocks for codes 0 and 3, every DIV_MID clocks for code 1, and every DIV_SLOW clocks for code 2.
- R8: In the clock after rate_code_o changes, the divider restarts. The first pulse at the new rate comes P+1 clocks after the change, where P is the new period, and no pulse appears before it.
- R9: While over-temperature is active, scan_tick_o keeps pulsing at the slow period; the scan is never stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lum0_i | input | 1 | Luminance select, low bit |
| lum1_i | input | 1 | Luminance select, high bit |
| temp_i | input | TEMP_W | Signed board temperature in degrees C |
| temp_valid_i | input | 1 | Strobe marking temp_i as a fresh reading |
| rate_code_o | output | 2 | Selected scan rate: 0 fast, 1 mid, 2 slow, 3 self-test |
| scan_tick_o | output | 1 | One-cycle scan enable at the selected rate |
| over_temp_o | output | 1 | Over-temperature state flag |

## Verification
On every cycle, the assertions check the following:
- the entry and exit transitions at the two thresholds;
- that the flag holds without a valid strobe;
- that the slow code is forced while hot;
- that the fast code is produced for a 00 select when cool;
- that the scan enable is a single-cycle pulse;
- that no pulse follows a rate change.

Only the bench scenarios can show the following:
- the exact pulse spacing at each rate;
- the P+1 spacing after a restart;
- the boundary readings at exactly 100 and 92;
- negative readings;
- the self-test code being overridden;
- reset clearing a latched hot state.

// File: rtl/thermal_lum_pkg.sv
package thermal_lum_pkg;

  // Scan-rate codes driven on rate_code_o
  typedef enum logic [1:0] {
    RATE_FAST     = 2'd0,
    RATE_MID      = 2'd1,
    RATE_SLOW     = 2'd2,
    RATE_SELFTEST = 2'd3
  } scan_rate_e;

endpackage

// File: rtl/thermal_rst_sync.sv
module thermal_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/thermal_hyst.sv
module thermal_hyst #(
  parameter int TEMP_W  = 10,
  parameter int ENTER_C = 100,
  parameter int EXIT_C  = 92
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic signed [TEMP_W-1:0] temp_i,
  input  logic                     temp_valid_i,
  output logic                     hot_o
);

  localparam logic signed [TEMP_W-1:0] ENTER_T = TEMP_W'(ENTER_C);
  localparam logic signed [TEMP_W-1:0] EXIT_T  = TEMP_W'(EXIT_C);

  logic hot_q;
  logic hot_d;
  logic hot_en;

  // Next-state: only strobed readings may move the latch
  always_comb begin
    hot_d  = hot_q;
    hot_en = 1'b0;
    if (temp_valid_i) begin
      if (!hot_q && (temp_i > ENTER_T)) begin
        hot_d  = 1'b1;
        hot_en = 1'b1;
      end else if (hot_q && (temp_i < EXIT_T)) begin
        hot_d  = 1'b0;
        hot_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hot_q <= 1'b0;
    end else if (hot_en) begin
      hot_q <= hot_d;
    end
  end

  assign hot_o = hot_q;

endmodule

// File: rtl/scan_rate_sel.sv
module scan_rate_sel
  import thermal_lum_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lum0_i,
  input  logic       lum1_i,
  input  logic       hot_i,
  output scan_rate_e code_o
);

  scan_rate_e code_q;
  scan_rate_e code_d;
  logic       code_en;

  always_comb begin
    unique case ({lum1_i, lum0_i})
      2'b00:   code_d = RATE_FAST;
      2'b01:   code_d = RATE_MID;
      2'b10:   code_d = RATE_SLOW;
      default: code_d = RATE_SELFTEST;
    endcase
    // Thermal override takes priority over every select combination
    if (hot_i) begin
      code_d = RATE_SLOW;
    end
    code_en = (code_d != code_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= RATE_FAST;
    end else if (code_en) begin
      code_q <= code_d;
    end
  end

  assign code_o = code_q;

endmodule

// File: rtl/scan_tick_div.sv
module scan_tick_div
  import thermal_lum_pkg::*;
#(
  parameter int DIV_FAST = 3077,
  parameter int DIV_MID  = 4167,
  parameter int DIV_SLOW = 5556
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  scan_rate_e code_i,
  output logic       tick_o
);

  localparam int DIV_TOP = (DIV_SLOW > DIV_MID) ?
                           ((DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST) :
                           ((DIV_MID  > DIV_FAST) ? DIV_MID  : DIV_FAST);
  localparam int CNT_W   = $clog2(DIV_TOP + 1);

  scan_rate_e       last_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] period;
  logic             tick_q;
  logic             tick_d;
  logic             changed;
  logic             wrap;

  always_comb begin
    unique case (code_i)
      RATE_MID:  period = CNT_W'(DIV_MID);
      RATE_SLOW: period = CNT_W'(DIV_SLOW);
      default:   period = CNT_W'(DIV_FAST);
    endcase
  end

  always_comb begin
    changed = (code_i != last_q);
    wrap    = (cnt_q == (period - CNT_W'(1)));
    if (changed || wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
    tick_d = wrap && !changed;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
      last_q <= RATE_FAST;
    end else begin
      cnt_q  <= cnt_d;
      tick_q <= tick_d;
      if (changed) begin
        last_q <= code_i;
      end
    end
  end

  assign tick_o = tick_q;

endmodule

// File: rtl/thermal_lum_ctrl.sv
module thermal_lum_ctrl
  import thermal_lum_pkg::*;
#(
  parameter int TEMP_W   = 10,
  parameter int ENTER_C  = 100,
  parameter int EXIT_C   = 92,
  parameter int DIV_FAST = 3077,
  parameter int DIV_MID  = 4167,
  parameter int DIV_SLOW = 5556
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     lum0_i,
  input  logic                     lum1_i,
  input  logic signed [TEMP_W-1:0] temp_i,
  input  logic                     temp_valid_i,
  output logic [1:0]               rate_code_o,
  output logic                     scan_tick_o,
  output logic                     over_temp_o
);

  logic       rst_n_int;
  logic       hot;
  scan_rate_e code;

  thermal_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_int)
  );

  thermal_hyst #(
    .TEMP_W  (TEMP_W),
    .ENTER_C (ENTER_C),
    .EXIT_C  (EXIT_C)
  ) u_hyst (
    .clk_i        (clk_i),
    .rst_ni       (rst_n_int),
    .temp_i       (temp_i),
    .temp_valid_i (temp_valid_i),
    .hot_o        (hot)
  );

  scan_rate_sel u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .lum0_i (lum0_i),
    .lum1_i (lum1_i),
    .hot_i  (hot),
    .code_o (code)
  );

  scan_tick_div #(
    .DIV_FAST (DIV_FAST),
    .DIV_MID  (DIV_MID),
    .DIV_SLOW (DIV_SLOW)
  ) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .code_i (code),
    .tick_o (scan_tick_o)
  );

  assign rate_code_o = code;
  assign over_temp_o = hot;

endmodule

// File: rtl/thermal_lum_chk.sv
module thermal_lum_chk #(
  parameter int TEMP_W  = 10,
  parameter int ENTER_C = 100,
  parameter int EXIT_C  = 92
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     lum0_i,
  input logic                     lum1_i,
  input logic signed [TEMP_W-1:0] temp_i,
  input logic                     temp_valid_i,
  input logic [1:0]               rate_code_o,
  input logic                     scan_tick_o,
  input logic                     over_temp_o
);

  localparam logic signed [TEMP_W-1:0] ENTER_T = TEMP_W'(ENTER_C);
  localparam logic signed [TEMP_W-1:0] EXIT_T  = TEMP_W'(EXIT_C);

  // R3
  a_r3_enter_above_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!over_temp_o && temp_valid_i && (temp_i > ENTER_T)) |=> over_temp_o);

  // R4
  a_r4_exit_below_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (over_temp_o && temp_valid_i && (temp_i < EXIT_T)) |=> !over_temp_o);

  // R5
  a_r5_hold_without_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !temp_valid_i |=> $stable(over_temp_o));

  // R6
  a_r6_hot_forces_slow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    over_temp_o |=> (rate_code_o == 2'd2));

  // R2
  a_r2_zero_select_fast: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!over_temp_o && !lum0_i && !lum1_i) |=> (rate_code_o == 2'd0));

  // R7
  a_r7_single_cycle_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_tick_o |=> !scan_tick_o);

  // R8
  a_r8_no_tick_after_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_code_o != $past(rate_code_o)) |=> !scan_tick_o);

endmodule

bind thermal_lum_ctrl thermal_lum_chk #(
  .TEMP_W  (TEMP_W),
  .ENTER_C (ENTER_C),
  .EXIT_C  (EXIT_C)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_n_int),
  .lum0_i       (lum0_i),
  .lum1_i       (lum1_i),
  .temp_i       (temp_i),
  .temp_valid_i (temp_valid_i),
  .rate_code_o  (rate_code_o),
  .scan_tick_o  (scan_tick_o),
  .over_temp_o  (over_temp_o)
);

// File: tb/thermal_lum_ctrl_tb.sv
`timescale 1ns/1ps
module thermal_lum_ctrl_tb;

  localparam int TW    = 10;
  localparam int PFAST = 4;
  localparam int PMID  = 6;
  localparam int PSLOW = 9;

  // Vector fields: [7] lum1, [6] lum0, [5:4] expected code, [3:0] expected period
  localparam logic [7:0] VEC [4] = '{
    {1'b0, 1'b0, 2'd0, 4'(PFAST)},
    {1'b0, 1'b1, 2'd1, 4'(PMID)},
    {1'b1, 1'b0, 2'd2, 4'(PSLOW)},
    {1'b1, 1'b1, 2'd3, 4'(PFAST)}
  };

  logic                 clk;
  logic                 rst_n;
  logic                 lum0;
  logic                 lum1;
  logic signed [TW-1:0] temp;
  logic                 tvalid;
  logic [1:0]           code;
  logic                 tick;
  logic                 hot;

  int  n_tests;
  int  n_fail;
  bit  done;

  thermal_lum_ctrl #(
    .TEMP_W   (TW),
    .ENTER_C  (100),
    .EXIT_C   (92),
    .DIV_FAST (PFAST),
    .DIV_MID  (PMID),
    .DIV_SLOW (PSLOW)
  ) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .lum0_i       (lum0),
    .lum1_i       (lum1),
    .temp_i       (temp),
    .temp_valid_i (tvalid),
    .rate_code_o  (code),
    .scan_tick_o  (tick),
    .over_temp_o  (hot)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input int act, input int exp, input string req);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Present one reading for one clock; sample just after the edge that takes it
  task automatic reading(input int t, input bit v);
    @(negedge clk);
    temp   = TW'(t);
    tvalid = v;
    step();
    @(negedge clk);
    tvalid = 1'b0;
  endtask

  // Edges between two consecutive ticks
  task automatic interval(output int gap);
    int guard;
    guard = 0;
    while (!tick && guard < 100) begin step(); guard++; end
    gap = 0;
    do begin step(); gap++; end while (!tick && gap < 100);
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    done    = 1'b0;
    rst_n   = 1'b0;
    lum0    = 1'b0;
    lum1    = 1'b0;
    temp    = '0;
    tvalid  = 1'b0;
    repeat (3) step();
    check(hot,  0, "R1 reset over_temp");
    check(code, 0, "R1 reset rate code");
    check(tick, 0, "R1 reset tick");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();

    // Table walk: select decoding and steady tick spacing (R2, R7)
    foreach (VEC[i]) begin
      int gap;
      @(negedge clk);
      lum1 = VEC[i][7];
      lum0 = VEC[i][6];
      step();
      check(code, int'(VEC[i][5:4]), "R2 select decode");
      interval(gap);
      interval(gap);
      check(gap, int'(VEC[i][3:0]), "R7 tick period");
    end

    // R8: restart on a rate change, fast -> slow
    @(negedge clk);
    lum1 = 1'b0; lum0 = 1'b0;
    repeat (PFAST + 3) step();
    @(negedge clk);
    lum1 = 1'b1;
    step();                                  // edge 1: code updates
    check(code, 2, "R8 code changed");
    begin
      int early;
      early = 0;
      for (int k = 2; k <= PSLOW + 1; k++) begin
        step();
        if (tick) early++;
      end
      check(early, 0, "R8 no tick before restart period");
      step();                                // edge PSLOW+2
      check(tick, 1, "R8 first tick after restart");
    end

    // Thermal behaviour
    @(negedge clk);
    lum1 = 1'b0; lum0 = 1'b0;
    reading(120, 1'b0);
    check(hot, 0, "R5 unstrobed hot reading ignored");
    reading(-40, 1'b1);
    check(hot, 0, "R5 negative reading stays cool");
    reading(100, 1'b1);
    check(hot, 0, "R3 reading equal to limit");
    @(negedge clk);
    temp = TW'(101); tvalid = 1'b1;
    step();
    check(hot, 1, "R3 enter above limit");
    @(negedge clk);
    tvalid = 1'b0;
    #3;
    @(posedge clk); #1;
    check(code, 2, "R6 forced slow code");
    @(negedge clk);
    lum1 = 1'b1; lum0 = 1'b1;
    repeat (2) step();
    check(code, 2, "R6 self-test select overridden");
    begin
      int gap;
      interval(gap);
      interval(gap);
      check(gap, PSLOW, "R9 tick keeps running while hot");
    end
    reading(92, 1'b1);
    check(hot, 1, "R4 reading equal to exit limit");
    reading(96, 1'b1);
    check(hot, 1, "R4 reading inside band");
    reading(10, 1'b0);
    check(hot, 1, "R5 unstrobed cool reading ignored");
    @(negedge clk);
    temp = TW'(91); tvalid = 1'b1;
    step();
    check(hot, 0, "R4 exit below limit");
    @(negedge clk);
    tvalid = 1'b0;
    step();
    check(code, 3, "R2 select restored after exit");

    // R1: reset clears a latched hot state
    reading(130, 1'b1);
    check(hot, 1, "R3 re-enter");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(hot, 0, "R1 reset clears over_temp");
    check(code, 0, "R1 reset clears code");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule